// File: doc/BRIEF.md
# GPIO Port Register Block

This block owns the control state of one general-purpose I/O port of eight pins and is accessed over a simple memory-mapped register bus. It holds three writable 8-bit registers and one read-only register. The first register hands each pin to GPIO control. The second makes each pin drive. The third holds the level each pin drives. The read-only register shows the pad inputs after synchronisation.

Each writable register is reachable at two addresses. A plain alias replaces the whole byte. A masked alias in an upper address window changes only the pins that the upper byte of the write data selects, so software can flip one pin without a read-modify-write. The block drives the pad output and output-enable lines directly from this state and tells the pin multiplexer which pins are in GPIO mode.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the mode, drive-enable and drive-level registers are all zero, and pad_oe, pad_out and gpio_mode are all zero.
- R2: A write to a plain alias (mode 0x00, drive-enable 0x10, drive-level 0x20) loads wdata[7:0] into that register at the strobe's clock edge, and wdata[15:8] has no effect.
- R3: A write to a masked alias (mode 0x80, drive-enable 0x90, drive-level 0xA0, that is the window base plus the plain offset) sets bit n of the register to wdata[n] when wdata[8+n] is 1 and leaves bit n unchanged when wdata[8+n] is 0.
- R4: For a pin in GPIO mode, pad_oe[n] equals the drive-enable bit n, and pad_out[n] equals the drive-level bit n while that pin is enabled to drive and 0 otherwise. Both follow a register write right after the write's clock edge.
- R5: For a pin whose mode bit is 0, pad_oe[n] and pad_out[n] are 0 whatever its drive-enable and drive-level bits hold. gpio_mode mirrors the mode register.
- R6: A read of 0x30 returns, in bits 7:0, pad_in as it stood two clock edges before the read strobe's edge, through a two-flop synchroniser. Bits 15:8 are zero.
- R7: A read of a plain or masked alias returns the register's value in bits 7:0 and zero in bits 15:8. A read of any other address, including 0xB0, returns zero.
- R8: A write to 0x30 or to any unmapped address changes no register and no pad output.
- R9: bus_rdata is registered. It carries the result one clock edge after a read strobe and holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data; bits 15:8 are the pin mask for masked aliases |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Level driven onto each pad |
| pad_oe | output | 8 | Per-pad output enable |
| gpio_mode | output | 8 | Pins currently under GPIO control |

## Verification
A write lands at the clock edge that samples its strobe. The pad outputs reflect the write immediately after that edge, so the bench checks them at the following falling edge. A read result appears one edge after its strobe, and the bench samples bus_rdata at the falling edge after that edge. A pad input change must stand for two edges before a read strobe, so the bench waits two full cycles after driving pad_in before it issues the read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // register selector produced by the address decoder
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_MODE = 3'd1,
    SEL_DREN = 3'd2,
    SEL_DLVL = 3'd3,
    SEL_PINS = 3'd4
  } reg_sel_e;

  // offsets from the port base
  localparam int OFS_MODE = 'h00;
  localparam int OFS_DREN = 'h10;
  localparam int OFS_DLVL = 'h20;
  localparam int OFS_PINS = 'h30;

  // number of writable registers (mode, drive enable, drive level)
  localparam int NUM_WREGS = 3;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MASK_BASE = 'h80
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              masked
);

  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_DREN  = ADDR_W'(OFS_DREN);
  localparam logic [ADDR_W-1:0] A_DLVL  = ADDR_W'(OFS_DLVL);
  localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(OFS_PINS);
  localparam logic [ADDR_W-1:0] AM_MODE = ADDR_W'(MASK_BASE + OFS_MODE);
  localparam logic [ADDR_W-1:0] AM_DREN = ADDR_W'(MASK_BASE + OFS_DREN);
  localparam logic [ADDR_W-1:0] AM_DLVL = ADDR_W'(MASK_BASE + OFS_DLVL);

  always_comb begin
    sel    = SEL_NONE;
    masked = 1'b0;
    if      (addr == A_MODE)  sel = SEL_MODE;
    else if (addr == A_DREN)  sel = SEL_DREN;
    else if (addr == A_DLVL)  sel = SEL_DLVL;
    else if (addr == A_PINS)  sel = SEL_PINS;
    else if (addr == AM_MODE) begin sel = SEL_MODE; masked = 1'b1; end
    else if (addr == AM_DREN) begin sel = SEL_DREN; masked = 1'b1; end
    else if (addr == AM_DLVL) begin sel = SEL_DLVL; masked = 1'b1; end
  end

  // R3: the masked window holds only writable registers
  always_comb begin
    if (masked) begin
      masked_only_writable_chk: assert (sel == SEL_MODE || sel == SEL_DREN || sel == SEL_DLVL);
    end
  end

endmodule

// File: rtl/gpio_wreg.sv
module gpio_wreg #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              masked,
  input  logic [2*PINS-1:0] wdata,
  output logic [PINS-1:0]   q
);

  // new register contents for a plain or a masked write
  function automatic logic [PINS-1:0] merge_write(
    input logic [PINS-1:0]   old_v,
    input logic [2*PINS-1:0] wd,
    input logic              use_mask
  );
    logic [PINS-1:0] sel_bits;
    sel_bits = use_mask ? wd[2*PINS-1:PINS] : {PINS{1'b1}};
    return (old_v & ~sel_bits) | (wd[PINS-1:0] & sel_bits);
  endfunction

  logic [PINS-1:0] next_q;
  assign next_q = merge_write(q, wdata, masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= next_q;
  end

  // R8
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

  // R3
  masked_keeps_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && masked) |=> (((q ^ $past(q)) & ~$past(wdata[2*PINS-1:PINS])) == '0));

  // R2
  plain_loads_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !masked) |=> (q == $past(wdata[PINS-1:0])));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pins_sync
);

  logic [PINS-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1    <= '0;
      pins_sync <= '0;
    end else begin
      stage1    <= pad_in;
      pins_sync <= stage1;
    end
  end

  // edges seen since reset, saturating at two
  logic [1:0] settle_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle_cnt <= 2'd0;
    else if (settle_cnt != 2'd2) settle_cnt <= settle_cnt + 2'd1;
  end

  // R6
  two_edge_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_cnt == 2'd2) |-> (pins_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int ADDR_W    = 8,
  parameter int MASK_BASE = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2*PINS-1:0] bus_wdata,
  output logic [2*PINS-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   gpio_mode
);

  localparam int DATA_W = 2 * PINS;

  reg_sel_e        dec_sel;
  logic            dec_masked;
  logic [PINS-1:0] wreg_q [NUM_WREGS];
  logic [NUM_WREGS-1:0] wreg_we;
  logic [PINS-1:0] pins_sync;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE)) u_dec (
    .addr   (bus_addr),
    .sel    (dec_sel),
    .masked (dec_masked)
  );

  for (genvar i = 0; i < NUM_WREGS; i++) begin : g_wreg
    localparam reg_sel_e THIS_SEL = reg_sel_e'(3'(i + 1));
    assign wreg_we[i] = bus_wr && (dec_sel == THIS_SEL);
    gpio_wreg #(.PINS(PINS)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wreg_we[i]),
      .masked (dec_masked),
      .wdata  (bus_wdata),
      .q      (wreg_q[i])
    );
  end

  gpio_in_sync #(.PINS(PINS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .pins_sync (pins_sync)
  );

  logic [PINS-1:0] mode_q, dren_q, dlvl_q;
  assign mode_q = wreg_q[0];
  assign dren_q = wreg_q[1];
  assign dlvl_q = wreg_q[2];

  // pad drive: only GPIO-mode pins obey drive enable and level
  function automatic logic [PINS-1:0] drive_enable(input logic [PINS-1:0] m, input logic [PINS-1:0] e);
    return m & e;
  endfunction

  function automatic logic [PINS-1:0] drive_level(input logic [PINS-1:0] m, input logic [PINS-1:0] e,
                                                  input logic [PINS-1:0] l);
    return m & e & l;
  endfunction

  assign gpio_mode = mode_q;
  assign pad_oe    = drive_enable(mode_q, dren_q);
  assign pad_out   = drive_level(mode_q, dren_q, dlvl_q);

  // read data selection, zero-extended
  function automatic logic [DATA_W-1:0] read_word(input reg_sel_e s, input logic [PINS-1:0] m,
                                                  input logic [PINS-1:0] e, input logic [PINS-1:0] l,
                                                  input logic [PINS-1:0] p);
    logic [PINS-1:0] b;
    case (s)
      SEL_MODE: b = m;
      SEL_DREN: b = e;
      SEL_DLVL: b = l;
      SEL_PINS: b = p;
      default:  b = '0;
    endcase
    return {{PINS{1'b0}}, b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= read_word(dec_sel, mode_q, dren_q, dlvl_q, pins_sync);
  end

  // R5
  no_drive_outside_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~gpio_mode) == '0) && ((pad_out & ~pad_oe) == '0));

  // R7
  upper_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PINS] == '0);

  // R9
  rdata_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R8
  unmapped_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (dec_sel == SEL_NONE || dec_sel == SEL_PINS)) |-> (wreg_we == '0));

endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic [7:0]  pad_in = 8'h00;
  logic [7:0]  pad_out, pad_oe, gpio_mode;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_reg [3];

  always #5 clk = ~clk;

  gpio_port_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .gpio_mode(gpio_mode)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // pad outputs predicted from the model registers
  task automatic chk_pads(input string req);
    logic [7:0] e_oe;
    e_oe = m_reg[0] & m_reg[1];
    chk({req, " pad_oe"}, {8'h00, pad_oe}, {8'h00, e_oe});
    chk({req, " pad_out"}, {8'h00, pad_out}, {8'h00, e_oe & m_reg[2]});
    chk({req, " gpio_mode"}, {8'h00, gpio_mode}, {8'h00, m_reg[0]});
  endtask

  task automatic chk_regs(input string req);
    logic [15:0] rd;
    for (int r = 0; r < 3; r++) begin
      bus_read(8'(r * 16), rd);
      chk(req, rd, {8'h00, m_reg[r]});
    end
  endtask

  function automatic bit is_mapped(input int a);
    return a == 'h00 || a == 'h10 || a == 'h20 || a == 'h30 ||
           a == 'h80 || a == 'h90 || a == 'hA0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    for (int r = 0; r < 3; r++) m_reg[r] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_pads("R1");
    chk_regs("R1");

    // R2 plain writes, upper byte garbage ignored
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = 8'(k * 91 + r * 17 + 5);
        bus_write(8'(r * 16), {8'(~d), d});
        m_reg[r] = d;
        chk_pads("R4");
        bus_read(8'(r * 16), rd);
        chk("R2 plain write", rd, {8'h00, d});
      end
    end

    // R3 masked writes, all 256 masks per register
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 256; k++) begin
        logic [7:0] msk, d;
        msk = 8'(k);
        d   = 8'(k * 73 + 29);
        bus_write(8'('h80 + r * 16), {msk, d});
        m_reg[r] = (m_reg[r] & ~msk) | (d & msk);
        chk_pads("R4 R5");
        bus_read(8'(r * 16), rd);
        chk("R3 masked write", rd, {8'h00, m_reg[r]});
        if (k % 32 == 0) begin
          bus_read(8'('h80 + r * 16), rd);
          chk("R7 masked alias read", rd, {8'h00, m_reg[r]});
        end
      end
    end

    // R5 non-GPIO pins: enable and level set, mode cleared
    bus_write(8'h10, 16'h00FF); m_reg[1] = 8'hFF;
    bus_write(8'h20, 16'h00FF); m_reg[2] = 8'hFF;
    bus_write(8'h00, 16'h0000); m_reg[0] = 8'h00;
    chk("R5 no drive oe", {8'h00, pad_oe}, 16'h0000);
    chk("R5 no drive out", {8'h00, pad_out}, 16'h0000);
    bus_write(8'h80, 16'h0404); m_reg[0] = 8'h04;
    chk_pads("R5 single pin");

    // R6 input register after synchroniser
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      pad_in = 8'(v ^ 8'h5A);
      @(negedge clk);
      @(negedge clk);
      bus_read(8'h30, rd);
      chk("R6 pad input", rd, {8'h00, 8'(v ^ 8'h5A)});
    end

    // R7 unmapped reads return zero
    for (int a = 0; a < 256; a++) begin
      if (!is_mapped(a)) begin
        bus_read(8'(a), rd);
        chk("R7 unmapped read", rd, 16'h0000);
      end
    end

    // R8 writes to input register and unmapped addresses ignored
    for (int a = 0; a < 256; a++) begin
      if (!is_mapped(a) || a == 'h30) begin
        bus_write(8'(a), 16'hFF00 | 16'(~m_reg[0]));
      end
    end
    chk_pads("R8");
    chk_regs("R8");

    // R9 read data holds between strobes
    bus_read(8'h10, rd);
    bus_write(8'h10, 16'h003C); m_reg[1] = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R9 rdata hold", bus_rdata, rd);
    bus_read(8'h10, rd);
    chk("R9 rdata update", rd, 16'h003C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule